// File: doc/BRIEF.md
# Set-Only Watchdog Supervisor with Reset-Pin Release Timing

This block supervises a small 8-bit controller. Once armed, it counts slow ticks taken from one bit of a free-running timer. If software does not kick it before the seventh tick, it pulls the shared open-drain reset line low. Arming comes from a hardwired strap sampled after power-on reset, or from a software register write of 1. Software cannot disarm the block. Every later write of 1 is a kick that returns the tick counter to zero.

While the reset is driven, the block watches the level sensed back from the pin. It lets go only after that level has read low for `MIN_LOW_CLKS` consecutive system clocks. Any high reading restarts that count. After release, the block passes through a one-cycle load state, where the enable is reloaded from the strap.

The controller has four named states. `ST_LOAD` samples the strap and is entered after power-on reset and after every release. `ST_OFF` means disarmed, with the counter held at zero. `ST_ARMED` counts ticks. `ST_FIRE` drives the reset pin. The transitions are:

- `ST_LOAD` goes to `ST_ARMED` when the strap is 1 or a kick arrives, and to `ST_OFF` otherwise.
- `ST_OFF` goes to `ST_ARMED` on a kick.
- `ST_ARMED` goes to `ST_FIRE` on expiry.
- `ST_FIRE` goes to `ST_LOAD` once the pin has been seen low for long enough.

Top module: `wdog_supervisor`

## Requirements
- R1: After power-on reset, `en_rd` becomes 1 one clock after reset release if `strap_en` is 1. From `ST_OFF`, a write (`wr_stb`=1, `wr_data`=1) sets `en_rd`=1 at the next clock. `en_rd`=1 means armed.
- R2: A write with `wr_data`=0 never changes `en_rd` or the tick count, whether the block is armed or not.
- R3: While armed, a write of 1 returns the tick counter to zero, so expiry needs seven further ticks.
- R4: While armed, the seventh tick since the counter was last cleared sets `pin_pull_low`=1 at that clock edge. `pin_pull_low`=1 means the pin is pulled low. The sixth tick does not.
- R5: A tick is a 0-to-1 transition of `tick_src` between two consecutive clocks. Holding `tick_src` high for several clocks counts as one tick.
- R6: While disarmed, ticks are ignored and the counter stays at zero.
- R7: `pin_pull_low` stays 1 until `pin_sense` has been sampled 0 on `MIN_LOW_CLKS` consecutive clocks (default 4). It drops at the clock that takes the last of those samples. A sample of 1 restarts the count.
- R8: On release, `en_rd` reads 0 for one clock, then takes the value of `strap_en`.
- R9: If a kick and a tick arrive in the same clock, the counter ends that clock at zero.
- R10: While `pin_pull_low`=1, writes have no effect and `en_rd` reads 0.
- R11: While `rst_n`=0, `pin_pull_low`=0 and `en_rd`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| strap_en | input | 1 | Hardwired auto-enable strap |
| wr_stb | input | 1 | Register write strobe for the enable bit |
| wr_data | input | 1 | Data bit of the write; 1 arms and kicks |
| tick_src | input | 1 | Selected bit of the free-running timer |
| pin_sense | input | 1 | Level sensed back from the reset pin, 0 = low |
| en_rd | output | 1 | Read-back of the enable bit |
| pin_pull_low | output | 1 | Open-drain control, 1 pulls the reset pin low |

## Verification
The assertions check these properties on every clock:
- An armed block stays armed unless it fires.
- A disarmed block never fires.
- A kick suppresses expiry on the following clock, even when a tick arrives in the same clock.
- Release happens only after exactly `MIN_LOW_CLKS` consecutive low samples, tracked by a counter in the checker.
- Writes made during the reset phase arm nothing.

Only the bench scenarios can show the exact seventh-tick timing, the single count for a held-high tick source, and the return to the strap value after release.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    typedef enum logic [1:0] {
        ST_LOAD  = 2'd0,
        ST_OFF   = 2'd1,
        ST_ARMED = 2'd2,
        ST_FIRE  = 2'd3
    } wd_state_e;
endpackage

// File: rtl/wdog_tick_edge.sv
module wdog_tick_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic src,
    output logic tick
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= src;
    end

    // one pulse per low-to-high transition of the timer bit
    assign tick = src & ~prev_q;
endmodule

// File: rtl/wdog_div7.sv
module wdog_div7 #(
    parameter int DIV = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    output logic expire
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    // the DIV-th step from zero is the expiry; a clear in the same cycle wins
    assign expire = step & ~clear & (cnt_q == LAST);
endmodule

// File: rtl/wdog_low_timer.sv
module wdog_low_timer #(
    parameter int MIN_LOW_CLKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic pin_low,
    output logic done
);
    localparam int W = $clog2(MIN_LOW_CLKS + 1);
    localparam logic [W-1:0] LAST = W'(MIN_LOW_CLKS - 1);

    logic [W-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (!arm || !pin_low) begin
            run_q <= '0;
        end else if (run_q != LAST) begin
            run_q <= run_q + 1'b1;
        end
    end

    assign done = arm & pin_low & (run_q == LAST);
endmodule

// File: rtl/wdog_ctrl_fsm.sv
module wdog_ctrl_fsm
    import wdog_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic strap_en,
    input  logic kick,
    input  logic expire,
    input  logic release_done,
    output logic en_out,
    output logic pull_out,
    output logic hold_clear
);
    wd_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_LOAD;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOAD:  state_d = (strap_en || kick) ? ST_ARMED : ST_OFF;
            ST_OFF:   if (kick) state_d = ST_ARMED;
            ST_ARMED: if (expire) state_d = ST_FIRE;
            ST_FIRE:  if (release_done) state_d = ST_LOAD;
            default:  state_d = ST_LOAD;
        endcase
    end

    always_comb begin
        en_out     = 1'b0;
        pull_out   = 1'b0;
        hold_clear = 1'b1;
        unique case (state_q)
            ST_LOAD:  ;
            ST_OFF:   ;
            ST_ARMED: begin
                en_out     = 1'b1;
                hold_clear = 1'b0;
            end
            ST_FIRE:  pull_out = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/wdog_supervisor.sv
module wdog_supervisor #(
    parameter int DIV          = 7,
    parameter int MIN_LOW_CLKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strap_en,
    input  logic wr_stb,
    input  logic wr_data,
    input  logic tick_src,
    input  logic pin_sense,
    output logic en_rd,
    output logic pin_pull_low
);
    logic kick, tick, expire, release_done, hold_clear;

    assign kick = wr_stb & wr_data;

    wdog_tick_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .src   (tick_src),
        .tick  (tick)
    );

    wdog_div7 #(.DIV(DIV)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (hold_clear | kick),
        .step   (tick),
        .expire (expire)
    );

    wdog_low_timer #(.MIN_LOW_CLKS(MIN_LOW_CLKS)) u_low (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (pin_pull_low),
        .pin_low (~pin_sense),
        .done    (release_done)
    );

    wdog_ctrl_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .strap_en     (strap_en),
        .kick         (kick),
        .expire       (expire),
        .release_done (release_done),
        .en_out       (en_rd),
        .pull_out     (pin_pull_low),
        .hold_clear   (hold_clear)
    );
endmodule

// File: rtl/wdog_supervisor_chk.sv
module wdog_supervisor_chk #(
    parameter int MIN_LOW_CLKS = 4
) (
    input logic clk,
    input logic rst_n,
    input logic wr_stb,
    input logic wr_data,
    input logic pin_sense,
    input logic en_rd,
    input logic pin_pull_low
);
    localparam int W = $clog2(MIN_LOW_CLKS + 1);
    logic [W-1:0] low_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) low_run <= '0;
        else if (pin_pull_low && !pin_sense) begin
            if (low_run != W'(MIN_LOW_CLKS)) low_run <= low_run + 1'b1;
        end else low_run <= '0;
    end

    AST_STAYS_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        (en_rd && !pin_pull_low) |=> (en_rd || pin_pull_low)); // R2
    AST_OFF_NO_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_rd && !pin_pull_low) |=> !pin_pull_low); // R6
    AST_KICK_NO_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (en_rd && wr_stb && wr_data) |=> !pin_pull_low); // R9
    AST_MIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pin_pull_low) |-> (low_run == W'(MIN_LOW_CLKS))); // R7
    AST_FIRE_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_pull_low && wr_stb && wr_data) |=> !en_rd); // R10
    AST_FIRE_FROM_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pin_pull_low) |-> $past(en_rd)); // R4
endmodule

bind wdog_supervisor wdog_supervisor_chk #(.MIN_LOW_CLKS(MIN_LOW_CLKS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_stb       (wr_stb),
    .wr_data      (wr_data),
    .pin_sense    (pin_sense),
    .en_rd        (en_rd),
    .pin_pull_low (pin_pull_low)
);

// File: tb/wdog_supervisor_tb_top.sv
module wdog_supervisor_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic strap_en = 1'b0, wr_stb = 1'b0, wr_data = 1'b0;
    logic tick_src = 1'b0, pin_sense = 1'b1;
    logic en_rd, pin_pull_low;
    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    wdog_supervisor dut_i (
        .clk(clk), .rst_n(rst_n), .strap_en(strap_en), .wr_stb(wr_stb),
        .wr_data(wr_data), .tick_src(tick_src), .pin_sense(pin_sense),
        .en_rd(en_rd), .pin_pull_low(pin_pull_low)
    );

    // fields: [5] wr_stb [4] wr_data [3] tick_src [2] pin_sense [1] exp pull [0] exp en
    localparam int NV = 27;
    localparam logic [5:0] VEC [NV] = '{
        6'b100100, // R2 write 0 while off
        6'b001100, // R6 tick while off
        6'b000100,
        6'b110101, // R1 arm by write
        6'b001101, 6'b000101, // tick 1
        6'b001101, 6'b000101, // tick 2
        6'b001101, 6'b100101, // tick 3, R2 write 0 while armed
        6'b001101, 6'b000101, // tick 4
        6'b001101, 6'b000101, // tick 5
        6'b001101, 6'b000101, // tick 6
        6'b001110,            // tick 7 -> R4 fire
        6'b000110,            // pin still high
        6'b110110,            // R10 write 1 during fire
        6'b000010, 6'b000010, // two low samples
        6'b000110,            // R7 high restarts
        6'b000010, 6'b000010, 6'b000010,
        6'b000000,            // fourth consecutive low -> release
        6'b000100             // R8 strap 0 -> stays off
    };

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk); #1;
    endtask

    task automatic one_tick();
        tick_src = 1'b1; cyc();
        tick_src = 1'b0; cyc();
    endtask

    initial begin
        #(5.0 * 150000);
        failures++;
        $display("FAIL watchdog timeout (all requirements) actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) cyc();
        check("R11 pull in reset", pin_pull_low, 1'b0);
        check("R11 en in reset", en_rd, 1'b0);
        rst_n = 1'b1;
        cyc();
        check("R1 strap 0 leaves disarmed", en_rd, 1'b0);

        for (int i = 0; i < NV; i++) begin
            wr_stb = VEC[i][5]; wr_data = VEC[i][4];
            tick_src = VEC[i][3]; pin_sense = VEC[i][2];
            cyc();
            check($sformatf("R2/R4/R6/R7/R10 table row %0d pull", i), pin_pull_low, VEC[i][1]);
            check($sformatf("R1/R8/R10 table row %0d en", i), en_rd, VEC[i][0]);
        end
        wr_stb = 1'b0; wr_data = 1'b0; pin_sense = 1'b1; tick_src = 1'b0;

        // strap-armed reset
        strap_en = 1'b1; rst_n = 1'b0; cyc();
        check("R11 en held in reset", en_rd, 1'b0);
        rst_n = 1'b1; cyc();
        check("R1 strap arms after reset", en_rd, 1'b1);

        repeat (6) one_tick();
        check("R3 no fire after six ticks", pin_pull_low, 1'b0);
        wr_stb = 1'b1; wr_data = 1'b1; tick_src = 1'b1; cyc();
        wr_stb = 1'b0; wr_data = 1'b0; tick_src = 1'b0; cyc();
        check("R9 kick with tick no fire", pin_pull_low, 1'b0);
        repeat (6) one_tick();
        check("R9 clear won: six ticks after kick no fire", pin_pull_low, 1'b0);
        tick_src = 1'b1; cyc();
        check("R4 seventh tick fires", pin_pull_low, 1'b1);
        tick_src = 1'b0;

        pin_sense = 1'b0;
        repeat (3) cyc();
        check("R7 held after three lows", pin_pull_low, 1'b1);
        cyc();
        check("R7 released after four lows", pin_pull_low, 1'b0);
        check("R8 en 0 in load cycle", en_rd, 1'b0);
        pin_sense = 1'b1; cyc();
        check("R8 strap 1 re-arms", en_rd, 1'b1);

        // R5: held-high source counts once
        tick_src = 1'b1; repeat (3) cyc();
        tick_src = 1'b0; cyc();
        repeat (5) one_tick();
        check("R5 held high counted once", pin_pull_low, 1'b0);
        tick_src = 1'b1; cyc();
        check("R5 seventh distinct tick fires", pin_pull_low, 1'b1);
        tick_src = 1'b0; cyc();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule